// File: doc/BRIEF.md
# Multi-Bank Busy Tracker with Status Polling

This block sits in the controller of a flash-style memory that has four banks. It records which bank, if any, is running a program or erase operation, and it steers every read. A read to an idle bank goes straight to array data in the same cycle, with no added latency. A read to the bank that is working returns a polling status word instead. The mux select and the status word are combinational from the read address and the registered operation state.

The embedded algorithms are stood in for by countdown timers, one for programs and one for erases. When an operation finishes, its bank goes back to array reads on its own. An erase can be suspended. The suspend takes effect after a fixed latency. While the erase is suspended, its countdown is held, the sectors it is not erasing can be read, and one program to another sector may run. A resume continues the erase from where it stopped.

Only one operation is accepted at a time. Any start request that is refused produces a one-cycle error pulse.

Top module: `multibank_busy_tracker`

## Requirements
- R1: After reset is released, all `bank_busy` bits are 0, `start_err` is 0, and a read selects array data (`rd_sel_status`=0).
- R2: An accepted program sets the busy bit of its bank, chosen by address bits [15:14], on the clock edge that samples the request. The bit stays set for exactly PROG_CYCLES (default 4) cycles, after which reads to that bank select array data again.
- R3: A read whose bank (address bits [15:14]) has no operation running gives `rd_sel_status`=0 and `status_word`=0 in the same cycle.
- R4: A read to the bank of a running program gives `rd_sel_status`=1 and `status_word` equal to the programmed data with bit 7 inverted.
- R5: An accepted erase keeps its bank busy for exactly ERASE_CYCLES (default 12) cycles. Reads to that bank give `rd_sel_status`=1 and `status_word`=0, so bit 7 reads 0.
- R6: A start request made while an operation is active, including an erase that is suspended or still suspending, is ignored. `start_err` is 1 in the cycle after the request, and the busy bits are unchanged.
- R7: After a suspend request to a running erase, the busy bit stays set for SUSP_LAT (default 2) cycles and then clears. The erase countdown is held for as long as the erase is suspended.
- R8: While an erase is suspended, a read to the suspended sector (address bits [15:11]) returns status, with `rd_sel_status`=1 and `status_word`=0. A read to another sector of the same bank selects array data.
- R9: While an erase is suspended, a program to any other sector is accepted and runs. A program to the suspended sector is refused with a `start_err` pulse and sets no busy bit.
- R10: A resume request is ignored while a program started during the suspend is still running. An accepted resume sets the erase bank busy again for the rest of the erase, so the busy time before the suspend and after the resume adds up to ERASE_CYCLES.
- R11: Driving `rst_n` low clears every busy bit, aborts any operation and drops the suspend state at once, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| prog_req | input | 1 | Start-program strobe |
| erase_req | input | 1 | Start-erase strobe; a program request in the same cycle takes precedence |
| op_addr | input | 16 | Address of the program or erase |
| op_data | input | 16 | Data to be programmed |
| susp_req | input | 1 | Erase-suspend strobe |
| resume_req | input | 1 | Erase-resume strobe |
| rd_req | input | 1 | Read request |
| rd_addr | input | 16 | Read address |
| rd_sel_status | output | 1 | Read mux select: 1 = status word, 0 = array data |
| status_word | output | 16 | Polling status for the read |
| bank_busy | output | 4 | One busy flag per bank |
| start_err | output | 1 | One-cycle pulse when a start request is refused |

## Verification
The hardest state to reach is a program running inside a suspended erase while a resume is presented. Getting there takes an erase that has run for a known number of cycles, a suspend that has passed its latency, and then a program to a different bank. The bench builds this sequence one cycle at a time. It counts the busy cycles before the suspend and checks that the cycles after the resume make up the rest of ERASE_CYCLES, which shows that the countdown was held and that the early resume was ignored. A program to the suspended sector and a reset asserted during a suspend are driven from the same setup.

// File: rtl/bank_tracker_pkg.sv
package bank_tracker_pkg;
  typedef enum logic [1:0] {
    SRC_ARRAY  = 2'd0,
    SRC_PROG   = 2'd1,
    SRC_ERASE  = 2'd2
  } rd_src_e;
endpackage

// File: rtl/bt_rst_sync.sv
module bt_rst_sync (
  input  logic clk,
  input  logic rst_ni,
  output logic rst_sync_no
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) stage_q <= '0;
    else         stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_sync_no = stage_q[1];
endmodule

// File: rtl/bt_op_timer.sv
module bt_op_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_ni,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             run,
  output logic             active,
  output logic             done
);
  logic             act_q, act_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  assign done   = act_q & run & (cnt_q == '0);
  assign active = act_q;
  assign cnt_en = load | (act_q & run);

  always_comb begin
    act_d = act_q;
    cnt_d = cnt_q;
    if (load) begin
      act_d = 1'b1;
      cnt_d = load_val;
    end else if (done) begin
      act_d = 1'b0;
    end else if (act_q && run) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      act_q <= act_d;
      if (cnt_en) cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/bt_read_steer.sv
module bt_read_steer
  import bank_tracker_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int DATA_W   = 16,
  parameter int BANK_W   = 2,
  parameter int SEC_W    = 5,
  parameter int POLL_BIT = 7
) (
  input  logic              rd_req,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic              p_act,
  input  logic [ADDR_W-1:0] p_addr,
  input  logic [DATA_W-1:0] p_data,
  input  logic              e_act,
  input  logic              e_susp,
  input  logic [ADDR_W-1:0] e_addr,
  output logic              rd_sel,
  output logic [DATA_W-1:0] status
);
  localparam logic [DATA_W-1:0] POLL_MASK = DATA_W'(1) << POLL_BIT;

  rd_src_e          src;
  logic [BANK_W-1:0] rd_bank, p_bank, e_bank;
  logic [SEC_W-1:0]  rd_sec, e_sec;

  assign rd_bank = rd_addr[ADDR_W-1 -: BANK_W];
  assign p_bank  = p_addr[ADDR_W-1 -: BANK_W];
  assign e_bank  = e_addr[ADDR_W-1 -: BANK_W];
  assign rd_sec  = rd_addr[ADDR_W-1 -: SEC_W];
  assign e_sec   = e_addr[ADDR_W-1 -: SEC_W];

  always_comb begin
    src = SRC_ARRAY;
    if (rd_req) begin
      if (p_act && (rd_bank == p_bank))
        src = SRC_PROG;
      else if (e_act && (rd_bank == e_bank) && (!e_susp || (rd_sec == e_sec)))
        src = SRC_ERASE;
    end
  end

  always_comb begin
    case (src)
      SRC_PROG:  status = p_data ^ POLL_MASK;
      SRC_ERASE: status = '0;
      default:   status = '0;
    endcase
  end

  assign rd_sel = (src != SRC_ARRAY);
endmodule

// File: rtl/multibank_busy_tracker.sv
module multibank_busy_tracker #(
  parameter int NUM_BANKS    = 4,
  parameter int ADDR_W       = 16,
  parameter int DATA_W       = 16,
  parameter int SEC_W        = 5,
  parameter int POLL_BIT     = 7,
  parameter int PROG_CYCLES  = 4,
  parameter int ERASE_CYCLES = 12,
  parameter int SUSP_LAT     = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 prog_req,
  input  logic                 erase_req,
  input  logic [ADDR_W-1:0]    op_addr,
  input  logic [DATA_W-1:0]    op_data,
  input  logic                 susp_req,
  input  logic                 resume_req,
  input  logic                 rd_req,
  input  logic [ADDR_W-1:0]    rd_addr,
  output logic                 rd_sel_status,
  output logic [DATA_W-1:0]    status_word,
  output logic [NUM_BANKS-1:0] bank_busy,
  output logic                 start_err
);
  localparam int BANK_W = $clog2(NUM_BANKS);
  localparam int MAX_C  = (PROG_CYCLES > ERASE_CYCLES) ? PROG_CYCLES : ERASE_CYCLES;
  localparam int CNT_W  = $clog2(MAX_C + 1);
  localparam int LAT_W  = $clog2(SUSP_LAT + 1);
  localparam logic [CNT_W-1:0] P_LOAD = CNT_W'(PROG_CYCLES - 1);
  localparam logic [CNT_W-1:0] E_LOAD = CNT_W'(ERASE_CYCLES - 1);
  localparam logic [LAT_W-1:0] L_LOAD = LAT_W'(SUSP_LAT - 1);

  logic rst_int_n;

  // Operation state
  logic              p_act, p_done, e_act, e_done;
  logic [ADDR_W-1:0] p_addr_q, e_addr_q;
  logic [DATA_W-1:0] p_data_q;
  logic              susp_q, susp_d;
  logic              susp_pend_q, susp_pend_d;
  logic [LAT_W-1:0]  lat_q, lat_d;
  logic              lat_en;
  logic              err_q, err_d;

  // Decisions
  logic prog_ok, erase_ok, susp_ok, resume_ok;
  logic [BANK_W-1:0] p_bank, e_bank;
  logic [SEC_W-1:0]  op_sec, e_sec;

  bt_rst_sync u_rst_sync (
    .clk         (clk),
    .rst_ni      (rst_n),
    .rst_sync_no (rst_int_n)
  );

  assign p_bank = p_addr_q[ADDR_W-1 -: BANK_W];
  assign e_bank = e_addr_q[ADDR_W-1 -: BANK_W];
  assign op_sec = op_addr[ADDR_W-1 -: SEC_W];
  assign e_sec  = e_addr_q[ADDR_W-1 -: SEC_W];

  assign prog_ok   = prog_req && !p_act && (!e_act || (susp_q && (op_sec != e_sec)));
  assign erase_ok  = erase_req && !prog_req && !p_act && !e_act;
  assign susp_ok   = susp_req && e_act && !susp_q && !susp_pend_q && !e_done;
  assign resume_ok = resume_req && susp_q && !p_act;
  assign err_d     = (prog_req && !prog_ok) || (erase_req && !erase_ok);

  bt_op_timer #(.CNT_W(CNT_W)) u_prog_timer (
    .clk      (clk),
    .rst_ni   (rst_int_n),
    .load     (prog_ok),
    .load_val (P_LOAD),
    .run      (1'b1),
    .active   (p_act),
    .done     (p_done)
  );

  bt_op_timer #(.CNT_W(CNT_W)) u_erase_timer (
    .clk      (clk),
    .rst_ni   (rst_int_n),
    .load     (erase_ok),
    .load_val (E_LOAD),
    .run      (!susp_q),
    .active   (e_act),
    .done     (e_done)
  );

  // Suspend sequencing
  always_comb begin
    susp_d      = susp_q;
    susp_pend_d = susp_pend_q;
    lat_d       = lat_q;
    lat_en      = 1'b0;
    if (susp_ok) begin
      susp_pend_d = 1'b1;
      lat_d       = L_LOAD;
      lat_en      = 1'b1;
    end else if (susp_pend_q) begin
      if (e_done) begin
        susp_pend_d = 1'b0;
      end else if (lat_q == '0) begin
        susp_pend_d = 1'b0;
        susp_d      = 1'b1;
      end else begin
        lat_d  = lat_q - 1'b1;
        lat_en = 1'b1;
      end
    end else if (resume_ok) begin
      susp_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      susp_q      <= 1'b0;
      susp_pend_q <= 1'b0;
      lat_q       <= '0;
      err_q       <= 1'b0;
      p_addr_q    <= '0;
      p_data_q    <= '0;
      e_addr_q    <= '0;
    end else begin
      susp_q      <= susp_d;
      susp_pend_q <= susp_pend_d;
      err_q       <= err_d;
      if (lat_en)   lat_q    <= lat_d;
      if (prog_ok)  p_addr_q <= op_addr;
      if (prog_ok)  p_data_q <= op_data;
      if (erase_ok) e_addr_q <= op_addr;
    end
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_busy
    assign bank_busy[b] = (p_act && (p_bank == BANK_W'(b))) ||
                          (e_act && !susp_q && (e_bank == BANK_W'(b)));
  end

  assign start_err = err_q;

  bt_read_steer #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .BANK_W   (BANK_W),
    .SEC_W    (SEC_W),
    .POLL_BIT (POLL_BIT)
  ) u_read_steer (
    .rd_req  (rd_req),
    .rd_addr (rd_addr),
    .p_act   (p_act),
    .p_addr  (p_addr_q),
    .p_data  (p_data_q),
    .e_act   (e_act),
    .e_susp  (susp_q),
    .e_addr  (e_addr_q),
    .rd_sel  (rd_sel_status),
    .status  (status_word)
  );
endmodule

// File: rtl/multibank_busy_tracker_chk.sv
module multibank_busy_tracker_chk #(
  parameter int NUM_BANKS = 4,
  parameter int ADDR_W    = 16
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 prog_req,
  input logic                 erase_req,
  input logic                 resume_req,
  input logic                 rd_req,
  input logic [ADDR_W-1:0]    rd_addr,
  input logic                 rd_sel_status,
  input logic [NUM_BANKS-1:0] bank_busy,
  input logic                 start_err,
  input logic                 susp_pend_q,
  input logic                 susp_q
);
  localparam int BANK_W = $clog2(NUM_BANKS);
  logic [BANK_W-1:0] rd_bank;
  assign rd_bank = rd_addr[ADDR_W-1 -: BANK_W];

  assert_one_op_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(bank_busy));

  assert_erase_reject_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (erase_req && (|bank_busy)) |=> start_err);

  assert_busy_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && bank_busy[rd_bank]) |-> rd_sel_status);

  assert_busy_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(|bank_busy) |-> $past(prog_req || erase_req || resume_req));

  assert_susp_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    susp_pend_q |-> (|bank_busy));

  assert_resume_wait_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (susp_q && resume_req && (|bank_busy)) |=> susp_q);

  assert_reset_clear_R11: assert property (@(posedge clk)
    !rst_n |-> (bank_busy == '0 && !susp_q));
endmodule

bind multibank_busy_tracker multibank_busy_tracker_chk #(
  .NUM_BANKS (NUM_BANKS),
  .ADDR_W    (ADDR_W)
) i_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .prog_req      (prog_req),
  .erase_req     (erase_req),
  .resume_req    (resume_req),
  .rd_req        (rd_req),
  .rd_addr       (rd_addr),
  .rd_sel_status (rd_sel_status),
  .bank_busy     (bank_busy),
  .start_err     (start_err),
  .susp_pend_q   (susp_pend_q),
  .susp_q        (susp_q)
);

// File: tb/test_multibank_busy_tracker.sv
module test_multibank_busy_tracker;
  localparam int PROG_CYCLES  = 4;
  localparam int ERASE_CYCLES = 12;

  typedef struct packed {
    logic [15:0] pa;
    logic [15:0] pd;
    logic [15:0] ra;
    logic        sel;
    logic [15:0] st;
  } vec_t;

  localparam vec_t VEC [6] = '{
    '{16'h0100, 16'h1234, 16'h0200, 1'b1, 16'h12B4},
    '{16'h4000, 16'h00FF, 16'h4ABC, 1'b1, 16'h007F},
    '{16'h8000, 16'hA5A5, 16'h0000, 1'b0, 16'h0000},
    '{16'hC123, 16'h8080, 16'hFFFF, 1'b1, 16'h8000},
    '{16'h3FFF, 16'h0000, 16'h4000, 1'b0, 16'h0000},
    '{16'h7000, 16'h0055, 16'h4000, 1'b1, 16'h00D5}
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        prog_req, erase_req, susp_req, resume_req, rd_req;
  logic [15:0] op_addr, op_data, rd_addr;
  logic        rd_sel_status;
  logic [15:0] status_word;
  logic [3:0]  bank_busy;
  logic        start_err;

  int n_chk = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  multibank_busy_tracker i_multibank_busy_tracker (
    .clk           (clk),
    .rst_n         (rst_n),
    .prog_req      (prog_req),
    .erase_req     (erase_req),
    .op_addr       (op_addr),
    .op_data       (op_data),
    .susp_req      (susp_req),
    .resume_req    (resume_req),
    .rd_req        (rd_req),
    .rd_addr       (rd_addr),
    .rd_sel_status (rd_sel_status),
    .status_word   (status_word),
    .bank_busy     (bank_busy),
    .start_err     (start_err)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic start_prog(input logic [15:0] a, input logic [15:0] d);
    prog_req = 1'b1; op_addr = a; op_data = d;
    tick();
    prog_req = 1'b0;
  endtask

  task automatic start_erase(input logic [15:0] a);
    erase_req = 1'b1; op_addr = a;
    tick();
    erase_req = 1'b0;
  endtask

  task automatic pulse_susp();
    susp_req = 1'b1; tick(); susp_req = 1'b0;
  endtask

  task automatic pulse_resume();
    resume_req = 1'b1; tick(); resume_req = 1'b0;
  endtask

  task automatic read_at(input logic [15:0] a);
    rd_req = 1'b1; rd_addr = a; #1;
  endtask

  task automatic count_busy(input int b, output int n);
    n = 0;
    while (bank_busy[b] && n < 1000) begin
      n++;
      tick();
    end
  endtask

  task automatic do_reset();
    #2 rst_n = 1'b0;
    #1 check(bank_busy == 4'b0, "R11 async clear", bank_busy, 0);
    repeat (2) tick();
    rst_n = 1'b1;
    repeat (3) tick();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int n, pre, post;
    rst_n = 1'b1; prog_req = 0; erase_req = 0; susp_req = 0; resume_req = 0;
    rd_req = 0; op_addr = '0; op_data = '0; rd_addr = '0;
    #1 rst_n = 1'b0;
    repeat (3) tick();
    rst_n = 1'b1;
    repeat (3) tick();
    read_at(16'h0000);
    check(bank_busy == 4'b0, "R1 busy", bank_busy, 0);
    check(rd_sel_status == 1'b0, "R1 sel", rd_sel_status, 0);
    check(start_err == 1'b0, "R1 err", start_err, 0);
    rd_req = 0;

    // Vector table: program, read, busy duration
    for (int i = 0; i < 6; i++) begin
      start_prog(VEC[i].pa, VEC[i].pd);
      check(start_err == 1'b0, "R2 accept", start_err, 0);
      read_at(VEC[i].ra);
      check(rd_sel_status == VEC[i].sel, VEC[i].sel ? "R4 sel" : "R3 sel", rd_sel_status, VEC[i].sel);
      check(status_word == VEC[i].st, VEC[i].sel ? "R4 status" : "R3 status", status_word, VEC[i].st);
      rd_req = 0;
      count_busy(int'(VEC[i].pa[15:14]), n);
      check(n == PROG_CYCLES, "R2 duration", n, PROG_CYCLES);
      read_at(VEC[i].pa);
      check(rd_sel_status == 1'b0, "R2 return to array", rd_sel_status, 0);
      rd_req = 0;
    end

    // R5: erase duration and status
    start_erase(16'h4000);
    read_at(16'h4321);
    check(rd_sel_status == 1'b1 && status_word == 16'h0, "R5 status", {rd_sel_status, status_word}, 32'h10000);
    read_at(16'h8000);
    check(rd_sel_status == 1'b0, "R3 other bank", rd_sel_status, 0);
    rd_req = 0;
    count_busy(1, n);
    check(n == ERASE_CYCLES, "R5 duration", n, ERASE_CYCLES);

    // R6: start while busy
    start_erase(16'h4000);
    start_prog(16'h8000, 16'h1111);
    check(start_err == 1'b1, "R6 err pulse", start_err, 1);
    check(bank_busy == 4'b0010, "R6 busy unchanged", bank_busy, 4'b0010);
    erase_req = 1'b1; op_addr = 16'hC000; tick(); erase_req = 1'b0;
    check(start_err == 1'b1 && bank_busy == 4'b0010, "R6 erase refused", {start_err, bank_busy}, 5'h12);
    tick();
    check(start_err == 1'b0, "R6 pulse width", start_err, 0);
    count_busy(1, n);

    // R7..R10: suspend with nested program
    start_erase(16'h8000);
    pre = 1;
    tick(); pre++;
    tick(); pre++;
    pulse_susp();
    check(bank_busy[2] == 1'b1, "R7 latency 1", bank_busy, 4'b0100);
    pre++;
    tick();
    check(bank_busy[2] == 1'b1, "R7 latency 2", bank_busy, 4'b0100);
    pre++;
    tick();
    check(bank_busy == 4'b0, "R7 suspended", bank_busy, 0);
    repeat (3) tick();
    check(bank_busy == 4'b0, "R7 held", bank_busy, 0);
    read_at(16'h8400);
    check(rd_sel_status == 1'b1 && status_word == 16'h0, "R8 erased sector", {rd_sel_status, status_word}, 32'h10000);
    read_at(16'h8800);
    check(rd_sel_status == 1'b0, "R8 other sector", rd_sel_status, 0);
    rd_req = 0;
    start_prog(16'h8010, 16'h2222);
    check(start_err == 1'b1 && bank_busy == 4'b0, "R9 same sector refused", {start_err, bank_busy}, 5'h10);
    start_prog(16'hC000, 16'h0001);
    check(start_err == 1'b0 && bank_busy == 4'b1000, "R9 other sector runs", {start_err, bank_busy}, 5'h08);
    read_at(16'hC000);
    check(rd_sel_status == 1'b1 && status_word == 16'h0081, "R4 nested status", {rd_sel_status, status_word}, 32'h10081);
    rd_req = 0;
    pulse_resume();
    count_busy(3, n);
    check(bank_busy == 4'b0, "R10 early resume ignored", bank_busy, 0);
    pulse_resume();
    check(bank_busy == 4'b0100, "R10 resumed", bank_busy, 4'b0100);
    count_busy(2, post);
    check(post == ERASE_CYCLES - pre, "R10 remaining cycles", post, ERASE_CYCLES - pre);

    // R11: reset mid-program, then mid-suspend
    start_prog(16'h4000, 16'h3333);
    tick();
    do_reset();
    check(bank_busy == 4'b0, "R11 after release", bank_busy, 0);
    start_erase(16'h8000);
    tick();
    pulse_susp();
    tick(); tick();
    do_reset();
    start_erase(16'h0000);
    check(start_err == 1'b0 && bank_busy == 4'b0001, "R11 suspend cleared", {start_err, bank_busy}, 5'h01);
    count_busy(0, n);
    check(n == ERASE_CYCLES, "R11 fresh erase", n, ERASE_CYCLES);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule